// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight external interrupt pins and turns activity on them into one level interrupt per pin plus an OR of all of them. Each pin input is brought into the clock domain through a two-flop synchronizer. A per-pin sense code then decides what counts as an event: a falling edge, a rising edge, either edge, a low level or a high level. An event latches into a pending flag. Software inspects that flag through the register port and clears it.

A pin drives its output only when three conditions hold together: the pin is pending, the pin is unmasked, and its 4-bit priority field is nonzero. Masking uses a pair of write-one registers. One register sets mask bits and the other clears them, so no read-modify-write is needed. The per-pin outputs also depend on a mode bit in a control register that selects individual per-pin signalling. The combined output ignores that mode bit.

Per-pin fields in the sense and priority registers are packed from the most significant end. Pin 0 therefore sits in the top bits. The one-bit-per-pin registers follow the same top-down ordering within the width of the access: a byte access places pin n at bit 7−n, and a word access places it at bit 31−n.

Top module: `extpin_irq_ctrl`

## Requirements
- R1: After reset the block is in the following state. Every pending flag is clear, every pin is masked, every priority field is 0, and the mode bit is 0. Both outputs are low. Reads of the sense (address 0), priority (address 1), pending (address 2) and control (address 5) registers return 0.
- R2: The sense register is at address 0, and pin n's sense field is SENSE_W bits wide at bit offset 32−(n+1)·SENSE_W. The priority register is at address 1, and pin n's field is 4 bits wide at offset 28−4n. Both registers read back what was written.
- R3: Sense code 1 (rising), code 0 (falling) and code 4 (either edge) set the pending flag on a matching edge of the synchronized pin. The flag can be read after the third rising clock edge that follows the pin change. In these modes the flag stays set after the pin returns, until software clears it.
- R4: Sense code 3 (high level) and code 2 (low level) set the pending flag while the synchronized pin is at the active level. If a clear arrives while that level persists, the flag remains set.
- R5: Pending flags are read at address 2 and written there as well. On a write, each pin whose bit is 0 is cleared, and each pin whose bit is 1 keeps its flag. A pin event in the same cycle as a clear wins over the clear. A byte access (reg_byte=1) uses bit 7−n of the low byte, and a word access uses bit 31−n.
- R6: A write to address 3 masks every pin whose bit (same ordering as R5) is 1. A write to address 4 unmasks every pin whose bit is 1. Bits written as 0 leave the mask unchanged. Both addresses read as 0.
- R7: A pin whose priority field is 0 drives no output, even when it is pending and unmasked. Any nonzero value lets the output through.
- R8: irq_o[n] is high exactly when pin n is pending, unmasked, has a nonzero priority, and the mode bit is 1. irq_any_o is high when any pin is pending, unmasked and has a nonzero priority, whatever the mode bit.
- R9: The control register is at address 5, and bit 23 of it is the mode bit. Every other bit of the control register reads as 0. When the mode bit is 0, all per-pin outputs are held low.
- R10: Sense codes 5 to 15 detect nothing, and no pending flag is set under them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_byte | input | 1 | 1 selects a byte-wide access for the one-bit-per-pin registers |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_o | output | NUM_PINS | Per-pin level interrupt outputs |
| irq_any_o | output | 1 | OR of all gated pin interrupts, independent of the mode bit |

## Verification
The bench builds the block with its default values: eight pins and 4-bit sense fields. With those values every sense field fills the register exactly, and the either-edge code can be represented. Every pin is swept through each valid sense code and through two invalid ones, while all other pins hold an invalid code. That sweep shows both that the field offset reaches the intended pin and that no other pin reacts. The sweep alternates byte and word accesses pin by pin, so both bit orderings of the pending register are covered.

// File: rtl/extpin_pkg.sv
package extpin_pkg;

  localparam int DATA_W = 32;
  localparam int PRIO_W = 4;

  localparam logic [2:0] A_SENSE  = 3'd0;
  localparam logic [2:0] A_PRIO   = 3'd1;
  localparam logic [2:0] A_FLAG   = 3'd2;
  localparam logic [2:0] A_MASK   = 3'd3;
  localparam logic [2:0] A_UNMASK = 3'd4;
  localparam logic [2:0] A_MODE   = 3'd5;

  typedef enum logic [3:0] {
    SNS_FALL = 4'd0,
    SNS_RISE = 4'd1,
    SNS_LOW  = 4'd2,
    SNS_HIGH = 4'd3,
    SNS_BOTH = 4'd4
  } sense_e;

  // Low bit of a field of width w belonging to pin p, packed from the top.
  function automatic int field_lsb(input int p, input int w);
    return DATA_W - (p + 1) * w;
  endfunction

  // Bit of pin p in a one-bit-per-pin register for a byte or word access.
  function automatic int flag_pos(input int p, input bit byte_acc);
    return byte_acc ? (7 - p) : (DATA_W - 1 - p);
  endfunction

endpackage

// File: rtl/extpin_sync.sv
module extpin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic prev_o
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      lvl_o  <= 1'b0;
      prev_o <= 1'b0;
    end else begin
      meta_q <= pin_i;
      lvl_o  <= meta_q;
      prev_o <= lvl_o;
    end
  end
endmodule

// File: rtl/extpin_detect.sv
module extpin_detect #(
  parameter int SENSE_W = 4
) (
  input  logic [SENSE_W-1:0] code_i,
  input  logic               lvl_i,
  input  logic               prev_i,
  output logic               hit_o
);
  import extpin_pkg::*;

  logic [3:0] code;
  logic rise, fall;

  assign code = 4'(code_i);
  assign rise = lvl_i & ~prev_i;
  assign fall = ~lvl_i & prev_i;

  always_comb begin
    case (code)
      SNS_FALL: hit_o = fall;
      SNS_RISE: hit_o = rise;
      SNS_LOW:  hit_o = ~lvl_i;
      SNS_HIGH: hit_o = lvl_i;
      SNS_BOTH: hit_o = rise | fall;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/extpin_pend.sv
module extpin_pend #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] hit_i,
  input  logic                clr_i,
  input  logic [NUM_PINS-1:0] keep_i,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] kept;

  assign kept = clr_i ? (pend_o & keep_i) : pend_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= kept | hit_i;
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
    // R3 R4: a detected event is always latched
    p_event_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i[n] |=> pend_o[n])
      else $error("event on pin %0d not latched", n);
    // R5: a zero written without a concurrent event clears the flag
    p_zero_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !keep_i[n] && !hit_i[n]) |=> !pend_o[n])
      else $error("pin %0d flag survived a clear", n);
  end
endmodule

// File: rtl/extpin_irq_ctrl.sv
module extpin_irq_ctrl #(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int MODE_BIT = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [2:0]          reg_addr,
  input  logic                reg_we,
  input  logic                reg_byte,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [NUM_PINS-1:0] irq_o,
  output logic                irq_any_o
);
  import extpin_pkg::*;

  localparam int SENSE_USED = NUM_PINS * SENSE_W;
  localparam int PRIO_USED  = NUM_PINS * PRIO_W;

  logic [NUM_PINS-1:0] hit, pend, keep, gate;
  logic [DATA_W-1:0]   sense_img, prio_img, flag_w;
  logic [7:0]          flag_b;
  logic                mode_q, flag_clr;

  assign flag_clr = reg_we && (reg_addr == A_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              mode_q <= 1'b0;
    else if (reg_we && reg_addr == A_MODE)   mode_q <= reg_wdata[MODE_BIT];
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam int SL   = field_lsb(n, SENSE_W);
    localparam int PL   = field_lsb(n, PRIO_W);
    localparam int WPOS = flag_pos(n, 1'b0);
    localparam int BPOS = flag_pos(n, 1'b1);

    logic [SENSE_W-1:0] sense_q;
    logic [PRIO_W-1:0]  prio_q;
    logic               mask_q, wbit, lvl, prev;

    assign wbit = reg_byte ? reg_wdata[BPOS] : reg_wdata[WPOS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sense_q <= '0;
        prio_q  <= '0;
        mask_q  <= 1'b1;
      end else if (reg_we) begin
        case (reg_addr)
          A_SENSE:  sense_q <= reg_wdata[SL +: SENSE_W];
          A_PRIO:   prio_q  <= reg_wdata[PL +: PRIO_W];
          A_MASK:   if (wbit) mask_q <= 1'b1;
          A_UNMASK: if (wbit) mask_q <= 1'b0;
          default:  ;
        endcase
      end
    end

    extpin_sync u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i[n]), .lvl_o(lvl), .prev_o(prev)
    );

    extpin_detect #(.SENSE_W(SENSE_W)) u_det (
      .code_i(sense_q), .lvl_i(lvl), .prev_i(prev), .hit_o(hit[n])
    );

    assign keep[n] = wbit;
    assign gate[n] = pend[n] & ~mask_q & (|prio_q);
    assign irq_o[n] = gate[n] & mode_q;

    assign sense_img[SL +: SENSE_W] = sense_q;
    assign prio_img[PL +: PRIO_W]   = prio_q;
    assign flag_w[WPOS]             = pend[n];
    assign flag_b[BPOS]             = pend[n];

    // R6: a mask write with this pin's bit set silences it next cycle
    p_mask_silences_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_MASK && wbit) |=> !irq_o[n])
      else $error("pin %0d active after mask", n);
    // R7: a zero priority field blocks the pin output
    p_prio_zero_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_PRIO && reg_wdata[PL +: PRIO_W] == '0) |=> !irq_o[n])
      else $error("pin %0d active with zero priority", n);
  end

  if (SENSE_USED < DATA_W) begin : g_sense_pad
    assign sense_img[DATA_W-SENSE_USED-1:0] = '0;
  end
  if (PRIO_USED < DATA_W) begin : g_prio_pad
    assign prio_img[DATA_W-PRIO_USED-1:0] = '0;
  end
  assign flag_w[DATA_W-NUM_PINS-1:0] = '0;
  if (NUM_PINS < 8) begin : g_flag_pad
    assign flag_b[7-NUM_PINS:0] = '0;
  end

  assign irq_any_o = |gate;

  extpin_pend #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(flag_clr),
    .keep_i(keep), .pend_o(pend)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SENSE: reg_rdata = sense_img;
      A_PRIO:  reg_rdata = prio_img;
      A_FLAG:  reg_rdata = reg_byte ? {24'd0, flag_b} : flag_w;
      A_MODE:  reg_rdata[MODE_BIT] = mode_q;
      default: reg_rdata = '0;
    endcase
  end

  // R9: clearing the mode bit holds every per-pin output low
  p_mode_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_MODE && !reg_wdata[MODE_BIT]) |=> (irq_o == '0))
    else $error("pin output active with mode bit cleared");
  // R8: any per-pin output implies the combined output
  p_any_covers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> irq_any_o)
    else $error("combined output missing");
endmodule

// File: tb/extpin_irq_ctrl_tb_top.sv
module extpin_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic        reg_byte = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_o;
  logic        irq_any_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  extpin_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_byte(reg_byte), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .irq_any_o(irq_any_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic b);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_byte = b; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic b, output logic [31:0] v);
    reg_addr = a; reg_byte = b;
    #1;
    v = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] pin_bit(input int p, input bit b);
    return 32'd1 << (b ? (7 - p) : (31 - p));
  endfunction

  task automatic chk_pin(input int p, input bit b, input bit e, input string tag);
    logic [31:0] v;
    rd(3'd2, b, v);
    chk({tag, " pending"}, v, e ? pin_bit(p, b) : 32'd0);
    chk({tag, " irq_o"}, {24'd0, irq_o}, e ? (32'd1 << p) : 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, 1'b0, v); chk("R1 sense", v, 32'd0);
    rd(3'd1, 1'b0, v); chk("R1 prio", v, 32'd0);
    rd(3'd2, 1'b0, v); chk("R1 pending", v, 32'd0);
    rd(3'd5, 1'b0, v); chk("R1 mode", v, 32'd0);
    chk("R1 outputs", {23'd0, irq_any_o, irq_o}, 32'd0);

    // R2 readback
    wr(3'd0, 32'hA5C31E70, 1'b0); rd(3'd0, 1'b0, v); chk("R2 sense readback", v, 32'hA5C31E70);
    wr(3'd1, 32'h12345678, 1'b0); rd(3'd1, 1'b0, v); chk("R2 prio readback", v, 32'h12345678);

    // open all gates
    wr(3'd1, 32'hFFFFFFFF, 1'b0);
    wr(3'd4, 32'h000000FF, 1'b1);
    wr(3'd5, 32'h00800000, 1'b0);

    // sweep: each pin through each code, others on an inert code
    for (int n = 0; n < 8; n++) begin
      for (int ci = 0; ci < 7; ci++) begin
        int c;
        bit b;
        logic [31:0] sns;
        string tag;
        c = (ci < 6) ? ci : 15;
        b = (n % 2 == 0);
        sns = '0;
        for (int k = 0; k < 8; k++)
          sns = sns | (32'((k == n) ? c : 7) << (32 - (k + 1) * 4));
        tag = (c == 0 || c == 1 || c == 4) ? "R3" : (c == 2 || c == 3) ? "R4" : "R10";
        tag = $sformatf("R2 %s pin%0d code%0d", tag, n, c);
        pins = '0;
        wr(3'd0, sns, 1'b0);
        settle();
        wr(3'd2, 32'd0, b);
        chk_pin(n, b, c == 2, {tag, " A"});
        @(negedge clk); pins[n] = 1'b1; settle();
        chk_pin(n, b, c == 1 || c == 2 || c == 3 || c == 4, {tag, " B"});
        wr(3'd2, 32'd0, b);
        chk_pin(n, b, c == 3, {tag, " C"});
        @(negedge clk); pins[n] = 1'b0; settle();
        chk_pin(n, b, c == 0 || c == 2 || c == 3 || c == 4, {tag, " D"});
        wr(3'd2, 32'd0, b);
        chk_pin(n, b, c == 2, {tag, " E"});
      end
    end

    // pins 3 and 5 on high level
    wr(3'd0, 32'h77737377, 1'b0);
    wr(3'd2, 32'd0, 1'b0);
    pins = 8'b0010_1000;
    settle();
    chk("R8 both pins out", {24'd0, irq_o}, 32'h28);
    chk("R8 combined", {31'd0, irq_any_o}, 32'd1);

    // R6 masking
    wr(3'd3, 32'h00000010, 1'b1);
    chk("R6 mask pin3 byte", {24'd0, irq_o}, 32'h20);
    rd(3'd3, 1'b0, v); chk("R6 mask reads zero", v, 32'd0);
    rd(3'd4, 1'b0, v); chk("R6 unmask reads zero", v, 32'd0);
    wr(3'd4, 32'd0, 1'b0);
    chk("R6 zero unmask no effect", {24'd0, irq_o}, 32'h20);
    wr(3'd4, 32'h10000000, 1'b0);
    chk("R6 unmask pin3 word", {24'd0, irq_o}, 32'h28);

    // R7 priority gate
    wr(3'd1, 32'hFFF0FFFF, 1'b0);
    chk("R7 prio zero blocks", {24'd0, irq_o}, 32'h20);
    rd(3'd2, 1'b1, v); chk("R7 still pending", v, 32'h14);
    wr(3'd1, 32'hFFF1FFFF, 1'b0);
    chk("R7 prio one passes", {24'd0, irq_o}, 32'h28);

    // R9 mode bit
    wr(3'd5, 32'd0, 1'b0);
    chk("R9 mode off outputs", {24'd0, irq_o}, 32'd0);
    chk("R8 combined ignores mode", {31'd0, irq_any_o}, 32'd1);
    wr(3'd5, 32'hFFFFFFFF, 1'b0);
    rd(3'd5, 1'b0, v); chk("R9 mode readback", v, 32'h00800000);
    chk("R9 mode on outputs", {24'd0, irq_o}, 32'h28);

    // R5 keep and clear, flags held by rising mode
    wr(3'd0, 32'h77717177, 1'b0);
    settle();
    wr(3'd2, 32'h000000FB, 1'b1);
    rd(3'd2, 1'b1, v); chk("R5 keep ones clear zeros", v, 32'h10);
    wr(3'd2, 32'd0, 1'b0);
    rd(3'd2, 1'b0, v); chk("R5 clear all", v, 32'd0);
    chk("R8 no pending no combined", {31'd0, irq_any_o}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule